// File: doc/BRIEF.md
# Prefix-Extended Immediate Logic Unit

This block is a one-instruction execute slice. It takes 16-bit instruction words, one per clock when a valid strobe is high, and carries out a bitwise AND of a register with an immediate. The results go to an internal file of eight 24-bit registers and to a 6-bit flag register. A separate prefix instruction can come first. It parks nine upper immediate bits, and the next AND splices those bits onto its own 7-bit field, so the operand becomes a full 16-bit mask instead of a sign-extended short one. If the instruction is marked as sitting in a branch delay slot, the splice is suppressed and the short form is used.

A two-state machine tracks the parked prefix. Its states are `EXT_IDLE` (no prefix waiting) and `EXT_PENDING` (prefix bits held). The transitions are:
- **arm**: `EXT_IDLE` to `EXT_PENDING` on a valid prefix.
- **re-arm**: `EXT_PENDING` to `EXT_PENDING` on a second valid prefix. The held bits are overwritten and a sticky error is raised.
- **consume**: `EXT_PENDING` to `EXT_IDLE` on any other valid word.
- **hold**: no change while the strobe is low.

Register contents and flags can be inspected through a combinational read port. Each instruction completes in the clock cycle it is presented, and its effect is visible after that edge.

Top module: `imm_logic_unit`

## Requirements
- R1: A synchronous active-high reset loads each register i with the 24-bit word `INIT_WORD` rotated left by 3*i bits, loads the flags with `FLAG_INIT`, leaves the machine in `EXT_IDLE` and clears the error bit.
- R2: A valid word whose bits 15..10 are 101000 is an AND. Bits 9..7 select the destination and bits 6..0 are a signed 7-bit immediate. With no prefix pending, that immediate is sign-extended to 16 bits and ANDed with bits 15..0 of the destination, so 0x7e acts as the mask 0xfffe.
- R3: An AND writes its 16-bit result to bits 15..0 of the destination, forces bits 23..16 to zero, and leaves every other register unchanged.
- R4: A valid word whose bits 15..13 are 110 is a prefix carrying a 9-bit value in bits 8..0. It writes no register, leaves the flags unchanged, and enters `EXT_PENDING`.
- R5: An AND that directly follows a prefix uses the 16-bit operand {prefix value, 7-bit field}, so a prefix of 0x3f with a field of 0x7f gives the mask 0x1fff.
- R6: Any valid word other than a prefix takes `EXT_PENDING` back to `EXT_IDLE`. A word that is neither AND nor prefix does this and has no other effect.
- R7: A prefix arriving while `EXT_PENDING` replaces the held value and sets the error output, which stays set until reset.
- R8: An AND flagged as a delay slot always uses the sign-extended 7-bit operand, even with a prefix pending, and still consumes the pending prefix.
- R9: The flag layout is bit 0 N, bit 1 Z, bit 2 V, bit 3 C, bit 4 IE, bit 5 IL. An AND sets N to result bit 15, sets Z when result bits 15..0 are all zero, and clears V. C, IE and IL never change after reset.
- R10: While `instr_valid` is low, no register, flag, pending state or error bit changes.
- R11: A valid word matching neither encoding changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| in_delay_slot | input | 1 | Word occupies a branch delay slot |
| rd_sel | input | 3 | Read-port register index |
| rd_data | output | 24 | Contents of the selected register |
| flags | output | 6 | Flag register (N, Z, V, C, IE, IL from bit 0) |
| ext_pending | output | 1 | High in `EXT_PENDING` |
| ext_error | output | 1 | Sticky double-prefix error |

## Verification
The assertions check the following on every cycle:
- the state machine enters `EXT_PENDING` after a prefix and leaves it after any other valid word;
- the error bit never falls;
- V is clear after every AND;
- C, IE and IL never move;
- a prefix or an idle cycle leaves the flags and the machine untouched.

Only the bench's scenarios can show that the numbers are right: the spliced versus sign-extended mask, the zeroed upper byte, the untouched neighbouring registers, and the N and Z values. For this, the bench runs random mixes of ANDs, prefixes, foreign words, delay-slot marks and idle cycles against a bench model.

// File: rtl/ilu_pkg.sv
package ilu_pkg;

    localparam int WORD_W = 16;
    localparam int IMM_W  = 7;
    localparam int EXT_W  = 9;
    localparam int FLAG_W = 6;

    // flag bit positions
    localparam int FL_N  = 0;
    localparam int FL_Z  = 1;
    localparam int FL_V  = 2;
    localparam int FL_C  = 3;
    localparam int FL_IE = 4;
    localparam int FL_IL = 5;

    // opcode patterns
    localparam logic [5:0] AND_OPC = 6'b101000;
    localparam logic [2:0] EXT_OPC = 3'b110;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_AND_IMM = 2'd1,
        OP_EXT     = 2'd2
    } op_kind_t;

    typedef enum logic {
        EXT_IDLE    = 1'b0,
        EXT_PENDING = 1'b1
    } ext_state_t;

    typedef struct packed {
        op_kind_t         kind;
        logic [2:0]       dst;
        logic [IMM_W-1:0] imm;
        logic [EXT_W-1:0] ext;
    } dec_t;

endpackage

// File: rtl/ilu_decoder.sv
module ilu_decoder
    import ilu_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);

    always_comb begin
        dec.dst = word[9:7];
        dec.imm = word[IMM_W-1:0];
        dec.ext = word[EXT_W-1:0];
        if (word[15:10] == AND_OPC) begin
            dec.kind = OP_AND_IMM;
        end else if (word[15:13] == EXT_OPC) begin
            dec.kind = OP_EXT;
        end else begin
            dec.kind = OP_NONE;
        end
    end

endmodule

// File: rtl/ilu_ext_ctrl.sv
module ilu_ext_ctrl
    import ilu_pkg::*;
#(
    parameter int PFX_W = EXT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             is_ext,
    input  logic [PFX_W-1:0] ext_in,
    output logic             pending,
    output logic [PFX_W-1:0] ext_val,
    output logic             ext_err
);

    ext_state_t       state_q;
    ext_state_t       state_d;
    logic [PFX_W-1:0] ext_q;
    logic             err_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EXT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: arm, re-arm, consume, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_IDLE: begin
                if (valid && is_ext) begin
                    state_d = EXT_PENDING;
                end
            end
            EXT_PENDING: begin
                if (valid && !is_ext) begin
                    state_d = EXT_IDLE;
                end
            end
            default: state_d = EXT_IDLE;
        endcase
    end

    // outputs: held prefix bits and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (valid && is_ext) begin
                ext_q <= ext_in;
            end
            if (valid && is_ext && (state_q == EXT_PENDING)) begin
                err_q <= 1'b1;
            end
        end
    end

    assign pending = (state_q == EXT_PENDING);
    assign ext_val = ext_q;
    assign ext_err = err_q;

    a_r4_prefix_arms: assert property (@(posedge clk) disable iff (rst)
        (valid && is_ext) |=> (state_q == EXT_PENDING));

    a_r6_consume: assert property (@(posedge clk) disable iff (rst)
        (valid && !is_ext) |=> (state_q == EXT_IDLE));

    a_r7_sticky_error: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(state_q) && $stable(ext_q) && $stable(err_q)));

endmodule

// File: rtl/ilu_imm_former.sv
module ilu_imm_former
    import ilu_pkg::*;
#(
    parameter int LO_W = IMM_W,
    parameter int HI_W = EXT_W,
    parameter int OP_W = WORD_W
) (
    input  logic [LO_W-1:0] field,
    input  logic [HI_W-1:0] upper,
    input  logic            use_upper,
    output logic [OP_W-1:0] operand
);

    localparam int SPLICE_W = LO_W + HI_W;

    logic [OP_W-1:0] short_form;
    logic [OP_W-1:0] long_form;

    assign short_form = {{(OP_W-LO_W){field[LO_W-1]}}, field};

    generate
        if (SPLICE_W >= OP_W) begin : g_full
            logic [SPLICE_W-1:0] joined;
            assign joined    = {upper, field};
            assign long_form = joined[OP_W-1:0];
        end else begin : g_part
            logic [SPLICE_W-1:0] joined;
            assign joined    = {upper, field};
            assign long_form = {{(OP_W-SPLICE_W){upper[HI_W-1]}}, joined};
        end
    endgenerate

    assign operand = use_upper ? long_form : short_form;

endmodule

// File: rtl/ilu_regfile.sv
module ilu_regfile #(
    parameter int                NREGS     = 8,
    parameter int                REG_W     = 24,
    parameter logic [REG_W-1:0]  INIT_WORD = 24'h5AF7BD,
    parameter int                ROT_STEP  = 3,
    localparam int               IDX_W     = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [IDX_W-1:0] ra_addr,
    output logic [REG_W-1:0] ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [REG_W-1:0] rb_data
);

    function automatic logic [REG_W-1:0] rotl(input logic [REG_W-1:0] x, input int n);
        int k;
        k = n % REG_W;
        if (k == 0) begin
            return x;
        end
        return (x << k) | (x >> (REG_W - k));
    endfunction

    logic [REG_W-1:0] cells [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = rotl(INIT_WORD, ROT_STEP * g);
        logic [REG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= RST_VAL;
            end else if (wr_en && (wr_addr == IDX_W'(g))) begin
                q <= wr_data;
            end
        end
        assign cells[g] = q;
    end

    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];

endmodule

// File: rtl/imm_logic_unit.sv
module imm_logic_unit
    import ilu_pkg::*;
#(
    parameter int                 NREGS     = 8,
    parameter int                 REG_W     = 24,
    parameter logic [REG_W-1:0]   INIT_WORD = 24'h5AF7BD,
    parameter logic [FLAG_W-1:0]  FLAG_INIT = 6'b101000,
    localparam int                IDX_W     = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    input  logic              in_delay_slot,
    input  logic [IDX_W-1:0]  rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic [FLAG_W-1:0] flags,
    output logic              ext_pending,
    output logic              ext_error
);

    dec_t              dec;
    logic              pending;
    logic [EXT_W-1:0]  ext_val;
    logic [WORD_W-1:0] operand;
    logic [REG_W-1:0]  src;
    logic [WORD_W-1:0] result;
    logic              and_fire;
    logic [FLAG_W-1:0] flags_q;

    ilu_decoder u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    ilu_ext_ctrl #(.PFX_W(EXT_W)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .valid   (instr_valid),
        .is_ext  (dec.kind == OP_EXT),
        .ext_in  (dec.ext),
        .pending (pending),
        .ext_val (ext_val),
        .ext_err (ext_error)
    );

    ilu_imm_former #(.LO_W(IMM_W), .HI_W(EXT_W), .OP_W(WORD_W)) u_imm (
        .field     (dec.imm),
        .upper     (ext_val),
        .use_upper (pending && !in_delay_slot),
        .operand   (operand)
    );

    assign and_fire = instr_valid && (dec.kind == OP_AND_IMM);
    assign result   = src[WORD_W-1:0] & operand;

    ilu_regfile #(
        .NREGS     (NREGS),
        .REG_W     (REG_W),
        .INIT_WORD (INIT_WORD),
        .ROT_STEP  (3)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (and_fire),
        .wr_addr (dec.dst[IDX_W-1:0]),
        .wr_data ({{(REG_W-WORD_W){1'b0}}, result}),
        .ra_addr (dec.dst[IDX_W-1:0]),
        .ra_data (src),
        .rb_addr (rd_sel),
        .rb_data (rd_data)
    );

    // flag register: only N, Z, V are ever written
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAG_INIT;
        end else if (and_fire) begin
            flags_q[FL_N] <= result[WORD_W-1];
            flags_q[FL_Z] <= (result == '0);
            flags_q[FL_V] <= 1'b0;
        end
    end

    assign flags       = flags_q;
    assign ext_pending = pending;

    a_r9_v_cleared: assert property (@(posedge clk) disable iff (rst)
        and_fire |=> !flags_q[FL_V]);

    a_r9_fixed_flags: assert property (@(posedge clk) disable iff (rst)
        ##1 $stable(flags_q[FL_IL:FL_C]));

    a_r4_prefix_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && dec.kind == OP_EXT) |=> $stable(flags_q));

    a_r10_flags_idle: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(flags_q));

    a_r8_slot_consumes: assert property (@(posedge clk) disable iff (rst)
        (and_fire && in_delay_slot) |=> !pending);

endmodule

// File: tb/imm_logic_unit_bench.sv
`timescale 1ns/100ps
module imm_logic_unit_bench;

    localparam logic [23:0] INIT_WORD = 24'h5AF7BD;
    localparam logic [5:0]  FLAG_INIT = 6'b101000;
    localparam int          MAX_CYC   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0;
    logic        in_delay_slot = 1'b0;
    logic [2:0]  rd_sel = 3'd0;
    logic [23:0] rd_data;
    logic [5:0]  flags;
    logic        ext_pending;
    logic        ext_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [23:0] m_reg [8];
    logic [5:0]  m_flags;
    logic        m_pend;
    logic [8:0]  m_ext;
    logic        m_err;

    always #2 clk = ~clk;

    imm_logic_unit u_imm_logic_unit (
        .clk           (clk),
        .rst           (rst),
        .instr_valid   (instr_valid),
        .instr_word    (instr_word),
        .in_delay_slot (in_delay_slot),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data),
        .flags         (flags),
        .ext_pending   (ext_pending),
        .ext_error     (ext_error)
    );

    function automatic logic [23:0] rot_left(input logic [23:0] x, input int n);
        int k;
        k = n % 24;
        if (k == 0) return x;
        return (x << k) | (x >> (24 - k));
    endfunction

    function automatic logic [15:0] mask_of(input logic [6:0] f, input logic [8:0] e, input logic use_e);
        if (use_e) return {e, f};
        return {{9{f[6]}}, f};
    endfunction

    function automatic logic [15:0] and_word(input logic [2:0] d, input logic [6:0] f);
        return {6'b101000, d, f};
    endfunction

    function automatic logic [15:0] ext_word(input logic [8:0] e, input logic [3:0] pad);
        return {3'b110, pad, e};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = rot_left(INIT_WORD, 3 * i);
        m_flags = FLAG_INIT;
        m_pend  = 1'b0;
        m_ext   = 9'h0;
        m_err   = 1'b0;
    endtask

    // compare all state through the read port; called shortly after a posedge
    task automatic compare_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.2;
            check(tag, 32'(rd_data[15:0]), 32'(m_reg[i][15:0]));
            check("R3 upper byte", 32'(rd_data[23:16]), 32'(m_reg[i][23:16]));
        end
        check("R9 flags", 32'(flags), 32'(m_flags));
        check("R6 pending", 32'(ext_pending), 32'(m_pend));
        check("R7 error", 32'(ext_error), 32'(m_err));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        instr_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        #0.3;
        compare_all("R1 reset");
    endtask

    task automatic issue(input logic v, input logic [15:0] w, input logic ds);
        string tag;
        logic [15:0] res;
        logic [15:0] m;
        logic [2:0] d;
        @(negedge clk);
        instr_valid   = v;
        instr_word    = w;
        in_delay_slot = ds;
        tag = "R10 idle";
        if (v) begin
            if (w[15:10] == 6'b101000) begin
                d = w[9:7];
                if (ds) tag = "R8 slot";
                else if (m_pend) tag = "R5 spliced";
                else tag = "R2 short";
                m = mask_of(w[6:0], m_ext, m_pend && !ds);
                res = m_reg[d][15:0] & m;
                m_reg[d] = {8'h00, res};
                m_flags[0] = res[15];
                m_flags[1] = (res == 16'h0);
                m_flags[2] = 1'b0;
                m_pend = 1'b0;
            end else if (w[15:13] == 3'b110) begin
                tag = "R4 prefix";
                if (m_pend) m_err = 1'b1;
                m_ext  = w[8:0];
                m_pend = 1'b1;
            end else begin
                tag = "R11 foreign";
                m_pend = 1'b0;
            end
        end
        @(posedge clk);
        #0.3;
        instr_valid = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        do_reset();

        // R2: 0x7e acts as 0xfffe on r0
        issue(1'b1, and_word(3'd0, 7'h7e), 1'b0);
        check("R2 example mask", 32'(m_reg[0][15:0]), 32'(rot_left(INIT_WORD, 0) & 24'h00fffe));

        // R5: prefix 0x3f then field 0x7f gives 0x1fff on r1
        issue(1'b1, ext_word(9'h03f, 4'h0), 1'b0);
        issue(1'b1, and_word(3'd1, 7'h7f), 1'b0);
        check("R5 example mask", 32'(m_reg[1][15:0]), 32'(rot_left(INIT_WORD, 3) & 24'h001fff));

        // R8: delay slot ignores pending prefix
        issue(1'b1, ext_word(9'h000, 4'h5), 1'b0);
        issue(1'b1, and_word(3'd2, 7'h7f), 1'b1);

        // R7: double prefix sets sticky error, second value is the one spliced
        issue(1'b1, ext_word(9'h1ff, 4'h0), 1'b0);
        issue(1'b1, ext_word(9'h0f0, 4'h3), 1'b0);
        issue(1'b1, and_word(3'd3, 7'h55), 1'b0);
        issue(1'b0, 16'h0, 1'b0);

        // R6 / R11: foreign word consumes prefix
        issue(1'b1, ext_word(9'h000, 4'h0), 1'b0);
        issue(1'b1, 16'h1234, 1'b0);
        issue(1'b1, and_word(3'd4, 7'h3f), 1'b0);

        // R9: zero result sets Z
        issue(1'b1, and_word(3'd5, 7'h00), 1'b0);

        // R10: idle cycles with junk on the bus
        issue(1'b0, and_word(3'd6, 7'h00), 1'b0);
        issue(1'b0, ext_word(9'h1aa, 4'h0), 1'b0);

        // random mix
        for (int n = 0; n < 2500; n++) begin
            int sel;
            logic [15:0] w;
            logic v;
            logic ds;
            if (n % 60 == 0) do_reset();
            sel = int'($urandom_range(0, 99));
            v = 1'b1;
            if (sel < 45) w = and_word(3'($urandom), 7'($urandom));
            else if (sel < 72) w = ext_word(9'($urandom), 4'($urandom));
            else if (sel < 86) w = {1'b0, 15'($urandom)};
            else begin
                v = 1'b0;
                w = 16'($urandom);
            end
            ds = ($urandom_range(0, 4) == 0);
            issue(v, w, ds);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule